// File: doc/BRIEF.md
# Subframe Status and Channel-Status Change Monitor

This block sits behind a biphase-mark decoder in the master-clock domain. The decoder raises a one-cycle strobe for each subframe it decodes. With the strobe it gives the user bit, the channel-status bit, a parity-error flag, the validity flag, the channel (left or right) and a marker that flags the first frame of a channel-status block. From these inputs the monitor drives four things. The first is a combined, non-latching error line. The second is a serial bit that carries either the user bit or the channel-status bit. The third is an active-low pulse once per subframe; a downstream device clocks the other status lines on its rising edge. The fourth is a latching interrupt.

The interrupt tracks the channel-status stream, using only the left channel. Within each block the monitor captures the first `CS_BITS` left-channel C bits, counted from the block marker. It compares them with the same bits of the block before. When they differ, the interrupt is raised, and it stays up until a read-clear strobe arrives. A status byte gives the separate parity and validity flags of the latest subframe and a copy of the interrupt. A `locked` input from the decoder shows whether the decoder holds lock. While lock is lost, the monitor ignores strobes and forgets the previous block.

Top module: `sfstat_mon`

## Requirements
- R1: One cycle after a strobe, `err_o` equals the strobe's parity-error flag OR its validity flag. It is 0 when both are 0.
- R2: `err_o` does not latch. A clean subframe that follows an erroneous one returns it to 0.
- R3: `status_o` holds the parity flag of the latest subframe in bit 0, the validity flag in bit 1 and a copy of `irq_o` in bit 5. All other bits are 0.
- R4: After each strobe, `sfclk_n_o` is low for exactly `PULSE_W` cycles, starting the cycle after the strobe. While it is low, `err_o` and `ser_bit_o` stay stable, so they are valid at its rising edge.
- R5: One cycle after a strobe, `ser_bit_o` carries the user bit when `sel_cs` is 0 and the channel-status bit when `sel_cs` is 1.
- R6: When the left-channel C bit at frame index `CS_BITS-1` of a block arrives, the monitor compares the block's first `CS_BITS` C bits with those of the previous block. If any bit differs, `irq_o` rises the next cycle.
- R7: `irq_o` latches. It stays high until a `stat_rd` pulse arrives, and it is low the cycle after that pulse.
- R8: The first complete block after reset raises no interrupt. The first complete block after `locked` goes low also raises no interrupt.
- R9: C bits received before the first block marker are discarded. Right-channel C bits (`sf_chan`=1) never take part in the comparison.
- R10: If `stat_rd` arrives in the same cycle as a new change event, the interrupt stays set.
- R11: While `locked` is 0, strobes are ignored and `err_o`, `ser_bit_o` and `status_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| locked | input | 1 | Decoder holds lock |
| sf_stb | input | 1 | One-cycle subframe strobe |
| sf_user | input | 1 | User bit of the subframe |
| sf_cstat | input | 1 | Channel-status bit of the subframe |
| sf_perr | input | 1 | Parity error seen in the subframe |
| sf_vflag | input | 1 | Validity flag (1 = sample not valid) |
| sf_chan | input | 1 | 0 = left, 1 = right |
| sf_blk | input | 1 | First frame of a channel-status block |
| sel_cs | input | 1 | Serial bit select: 0 user, 1 channel status |
| stat_rd | input | 1 | Status read strobe; clears the interrupt |
| err_o | output | 1 | Combined parity/validity error |
| ser_bit_o | output | 1 | Selected serial user or C bit |
| sfclk_n_o | output | 1 | Active-low subframe clock pulse |
| irq_o | output | 1 | Latching channel-status change interrupt |
| status_o | output | 8 | Status byte |

## Verification
The embedded properties check the per-subframe timing on every cycle. They cover the error OR and the serial bit selection one cycle after each strobe, and the low pulse that starts after a strobe. They also check that the outputs hold while the pulse is low, that the interrupt holds without a read and drops after a read, and that a read never clears a coinciding new event. The comparison itself needs whole blocks of stimulus, and only the bench scenarios can show it. Those scenarios cover the silent first block after reset and after loss of lock, the bits discarded before the first marker, the right-channel bits that are ignored, and the case where a changed bit raises the interrupt.

// File: rtl/sfstat_mon.sv
module sfstat_mon #(
  parameter int CS_BITS      = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int PULSE_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       locked,
  input  logic       sf_stb,
  input  logic       sf_user,
  input  logic       sf_cstat,
  input  logic       sf_perr,
  input  logic       sf_vflag,
  input  logic       sf_chan,
  input  logic       sf_blk,
  input  logic       sel_cs,
  input  logic       stat_rd,
  output logic       err_o,
  output logic       ser_bit_o,
  output logic       sfclk_n_o,
  output logic       irq_o,
  output logic [7:0] status_o
);

  localparam int FW = $clog2(BLOCK_FRAMES);
  localparam int CW = $clog2(CS_BITS);
  localparam int PW = $clog2(PULSE_W + 1);

  logic               stb_ok;
  logic               left_stb;
  logic [FW-1:0]      fidx;
  logic [FW-1:0]      fidx_eff;
  logic               started;
  logic               have_prev;
  logic [CS_BITS-1:0] cur_cs;
  logic [CS_BITS-1:0] prev_cs;
  logic [CS_BITS-1:0] cap_next;
  logic               capture;
  logic               commit;
  logic               irq_set;
  logic [PW-1:0]      lo_cnt;
  logic               perr_q;
  logic               vflag_q;

  assign stb_ok   = sf_stb && locked;
  assign left_stb = stb_ok && !sf_chan;
  assign fidx_eff = sf_blk ? '0 : fidx;
  assign capture  = left_stb && (sf_blk || (started && (fidx < FW'(CS_BITS))));
  assign commit   = capture && (fidx_eff == FW'(CS_BITS - 1));

  always_comb begin
    cap_next = cur_cs;
    if (capture) cap_next[fidx_eff[CW-1:0]] = sf_cstat;
  end

  assign irq_set = commit && have_prev && (cap_next != prev_cs);

  always_ff @(posedge clk) begin
    if (!rst_n || !locked) begin
      fidx      <= '0;
      started   <= 1'b0;
      have_prev <= 1'b0;
      cur_cs    <= '0;
      prev_cs   <= '0;
    end else if (left_stb) begin
      if (sf_blk) begin
        started <= 1'b1;
        fidx    <= FW'(1);
      end else if (started && fidx != FW'(BLOCK_FRAMES - 1)) begin
        fidx <= fidx + FW'(1);
      end
      if (capture) cur_cs <= cap_next;
      if (commit) begin
        prev_cs   <= cap_next;
        have_prev <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_set || (irq_o && !stat_rd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_o     <= 1'b0;
      ser_bit_o <= 1'b0;
      perr_q    <= 1'b0;
      vflag_q   <= 1'b0;
    end else if (stb_ok) begin
      err_o     <= sf_perr | sf_vflag;
      ser_bit_o <= sel_cs ? sf_cstat : sf_user;
      perr_q    <= sf_perr;
      vflag_q   <= sf_vflag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               lo_cnt <= '0;
    else if (stb_ok)          lo_cnt <= PW'(PULSE_W);
    else if (lo_cnt != '0)    lo_cnt <= lo_cnt - PW'(1);
  end

  assign sfclk_n_o = (lo_cnt == '0);
  assign status_o  = {2'b00, irq_o, 3'b000, vflag_q, perr_q};

  p_err_or_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && locked) |=> (err_o == ($past(sf_perr) | $past(sf_vflag))));

  p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && locked) |=> (ser_bit_o == ($past(sel_cs) ? $past(sf_cstat) : $past(sf_user))));

  p_pulse_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && locked) |=> !sfclk_n_o);

  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfclk_n_o && !sf_stb) |=> ($stable(err_o) && $stable(ser_bit_o)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stat_rd) |=> irq_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !irq_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && irq_set) |=> irq_o);

  p_first_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !have_prev && !irq_o) |=> !irq_o);

  p_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked) |=> ($stable(err_o) && $stable(ser_bit_o)));

endmodule

// File: tb/sfstat_mon_bench.sv
module sfstat_mon_bench;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic locked = 1'b0;
  logic sf_stb = 1'b0, sf_user = 1'b0, sf_cstat = 1'b0, sf_perr = 1'b0;
  logic sf_vflag = 1'b0, sf_chan = 1'b0, sf_blk = 1'b0, sel_cs = 1'b0, stat_rd = 1'b0;
  logic err_o, ser_bit_o, sfclk_n_o, irq_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sfstat_mon #(.CS_BITS(32), .BLOCK_FRAMES(192), .PULSE_W(PW)) u_sfstat_mon (
    .clk(clk), .rst_n(rst_n), .locked(locked), .sf_stb(sf_stb), .sf_user(sf_user),
    .sf_cstat(sf_cstat), .sf_perr(sf_perr), .sf_vflag(sf_vflag), .sf_chan(sf_chan),
    .sf_blk(sf_blk), .sel_cs(sel_cs), .stat_rd(stat_rd), .err_o(err_o),
    .ser_bit_o(ser_bit_o), .sfclk_n_o(sfclk_n_o), .irq_o(irq_o), .status_o(status_o));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_sf(input logic u, input logic c, input logic pe, input logic vf,
                         input logic ch, input logic bk, input logic rd);
    @(negedge clk);
    sf_stb = 1'b1; sf_user = u; sf_cstat = c; sf_perr = pe; sf_vflag = vf;
    sf_chan = ch; sf_blk = bk; stat_rd = rd;
    @(negedge clk);
    sf_stb = 1'b0; sf_blk = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_block(input logic [31:0] bits, input logic exp_irq,
                            input logic rd_at_commit, input string req);
    for (int f = 0; f < 40; f++) begin
      logic cb;
      cb = (f < 32) ? bits[f] : 1'b0;
      send_sf(1'b0, cb, 1'b0, 1'b0, 1'b0, f == 0, rd_at_commit && f == 31);
      if (f == 31) check(req, {7'd0, irq_o}, {7'd0, exp_irq});
      idle(8);
      send_sf(1'b0, ~bits[f % 32], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      idle(8);
    end
  endtask

  task automatic do_read(input logic exp_after, input string req);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check(req, {7'd0, irq_o}, {7'd0, exp_after});
  endtask

  task automatic t_reset;
    check("R1 reset err", {7'd0, err_o}, 8'd0);
    check("R4 reset sfclk", {7'd0, sfclk_n_o}, 8'd1);
    check("R7 reset irq", {7'd0, irq_o}, 8'd0);
    check("R3 reset status", status_o, 8'd0);
  endtask

  task automatic t_error;
    for (int k = 0; k < 4; k++) begin
      send_sf(1'b0, 1'b0, k[0], k[1], 1'b0, 1'b0, 1'b0);
      check("R1 err OR", {7'd0, err_o}, {7'd0, k[0] | k[1]});
      check("R3 status bits", status_o, {6'd0, k[1], k[0]});
      idle(8);
    end
    send_sf(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(8);
    send_sf(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R2 err clears", {7'd0, err_o}, 8'd0);
    idle(8);
  endtask

  task automatic t_sel;
    for (int k = 0; k < 8; k++) begin
      sel_cs = k[2];
      send_sf(k[0], k[1], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R5 serial select", {7'd0, ser_bit_o}, {7'd0, k[2] ? k[1] : k[0]});
      idle(8);
    end
    sel_cs = 1'b0;
  endtask

  task automatic t_pulse;
    send_sf(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < PW; c++) begin
      check("R4 pulse low", {7'd0, sfclk_n_o}, 8'd0);
      check("R4 err held", {7'd0, err_o}, 8'd1);
      @(negedge clk);
    end
    check("R4 pulse ends", {7'd0, sfclk_n_o}, 8'd1);
    idle(8);
  endtask

  task automatic t_chanstat;
    logic [31:0] a, b, c, d;
    a = 32'h1234_5678; b = a ^ 32'h0002_0000; c = b ^ 32'h8000_0000; d = c ^ 32'h0000_00ff;
    for (int f = 0; f < 10; f++) begin
      send_sf(1'b0, f[0], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(8);
    end
    send_block(a, 1'b0, 1'b0, "R8 first block silent");
    send_block(a, 1'b0, 1'b0, "R9 same bits, right ch and pre-marker bits ignored");
    send_block(b, 1'b1, 1'b0, "R6 changed bit raises irq");
    check("R3 status mirror", status_o & 8'h20, 8'h20);
    idle(20);
    check("R7 irq held", {7'd0, irq_o}, 8'd1);
    do_read(1'b0, "R7 read clears");
    send_block(c, 1'b1, 1'b1, "R10 set wins over read");
    do_read(1'b0, "R7 read clears again");
    @(negedge clk); locked = 1'b0;
    send_sf(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R11 err ignored unlocked", {7'd0, err_o}, 8'd0);
    check("R11 status kept", status_o, 8'd0);
    idle(8);
    locked = 1'b1;
    send_block(d, 1'b0, 1'b0, "R8 silent after relock");
    send_block(a, 1'b1, 1'b0, "R6 change after relock");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1; locked = 1'b1;
    @(negedge clk);
    t_reset();
    t_error();
    t_sel();
    t_pulse();
    t_chanstat();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule